// File: doc/BRIEF.md
# SAR Conversion Sequencer with Bus-Activity Deferral

This block sequences a successive-approximation analog-to-digital conversion. It divides its input clock by a parameter (four by default), so each bit trial lasts four clocks. It presents trial codes to an external DAC and reads an external comparator once per trial. Twelve trials settle the data bits. A thirteenth trial presents an all-ones code and decides whether the input is out of range. One more trial period then hands the 13-bit result to a downstream FIFO with a single-cycle write strobe.

A conversion begins on a low-to-high transition of the start input. The comparator and DAC are outside the block. A host bus shares the chip, and switching its data lines would disturb the comparator. So whenever a bus access (select low with read or write low) is seen on the falling clock edge just before a decision edge, that decision waits one clock. The check repeats on every following edge. A conversion therefore takes 56 clocks when the bus is quiet, plus one clock per deferred decision.

Top module: `sarseq_core`

## Requirements
- R1: After reset `dac_code_o` is 0, `word_o` is 0 and `word_wr_o` is 0.
- R2: While idle, the first rising clock edge that samples `start_i` high after a sampled low (edge 1) starts a conversion, and `dac_code_o` shows the MSB trial code 0x800 after that edge.
- R3: With a quiet bus, data decisions happen on edges 4, 8, …, 48, one every four clocks; the trial code does not change between decision edges.
- R4: At a data decision a high `comp_i` (input at or above the trial code) keeps the bit under trial and a low clears it; the next lower bit is then set. With an ideal comparator the 12-bit result is min(A, 4095).
- R5: After the twelfth decision `dac_code_o` is all ones (0xFFF) for the range trial; `comp_i` sampled at that decision (edge 52) becomes bit 12 of the result word (1 = out of range).
- R6: With no deferrals `word_wr_o` is high for exactly the one cycle after edge 56; `word_o` holds {range bit in bit 12, data in bits 11:0} from then until the next transfer.
- R7: If `bus_sel_n` is low and `bus_rd_n` or `bus_wr_n` is low at the falling edge just before a data or range decision edge, that decision is deferred by one clock, and the conversion lengthens by one clock.
- R8: The deferral check repeats on every following edge, so an access held over k falling edges before a decision adds k clocks.
- R9: No deferral occurs when `bus_sel_n` is high, when the access does not cover the falling edge before a decision edge, or when it falls before the transfer edge.
- R10: A start transition during a conversion is ignored: the result and its timing are unchanged, and no second conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; the trial clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Convert-start level; a rising transition starts a conversion |
| comp_i | input | 1 | Comparator result, high when the input is at or above the trial code |
| bus_sel_n | input | 1 | Host bus select, active low |
| bus_rd_n | input | 1 | Host bus read strobe, active low |
| bus_wr_n | input | 1 | Host bus write strobe, active low |
| dac_code_o | output | 12 | Trial code to the DAC |
| word_o | output | 13 | Completed result: range flag in bit 12, data in bits 11:0 |
| word_wr_o | output | 1 | One-cycle write strobe for `word_o` |

## Verification
The bench targets the edges of the deferral window. It places one access just before a decision edge, holds another across three decision edges, places one just after a decision edge, and puts one before the range decision and one before the transfer edge. A design that gated the wrong edge, or that also gated the transfer, would report a conversion length that is off by a clock or more. Inputs of 4094, 4095 and above full scale probe the range trial; a wrong range code or a wrong comparator capture shows up as a wrong bit 12. A restart pulse in the middle of a conversion would corrupt the result or start a second conversion if it were not ignored.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_DATA  = 2'd1,
      PH_RANGE = 2'd2,
      PH_XFER  = 2'd3
   } sar_phase_e;
endpackage

// File: rtl/sarseq_busgate.sv
// Samples host bus activity on the falling clock edge; the result tells the
// following rising edge whether it may strobe the comparator.
module sarseq_busgate #(
   parameter bit SLIP_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_sel_n,
   input  logic bus_rd_n,
   input  logic bus_wr_n,
   output logic bus_hold
);
   generate
      if (SLIP_EN) begin : g_sample
         logic hold_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= !bus_sel_n && (!bus_rd_n || !bus_wr_n);
         end
         assign bus_hold = hold_q;
      end else begin : g_never
         logic unused_bus;
         assign unused_bus = bus_sel_n ^ bus_rd_n ^ bus_wr_n;
         assign bus_hold   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/sarseq_divider.sv
// Trial-period counter: counts DIV input clocks per trial and freezes on its
// last count while a decision is deferred.
module sarseq_divider #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   input  logic stall,
   output logic at_end
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("sarseq_divider: DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign at_end = (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (load)             cnt <= CW'(1);
      else if (run && !stall)    cnt <= at_end ? '0 : cnt + CW'(1);
   end

   // R3: the edge that accepts a start is edge 1 of the first trial
   a_r3_first_count: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == CW'(1)));
   // R8: a deferred decision stays pending on the next edge
   a_r8_stall_keeps_end: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> at_end);
endmodule

// File: rtl/sarseq_sar.sv
// Successive-approximation register: trial bit walking, range flag capture
// and the DAC code multiplexer.
module sarseq_sar #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         dec_data,
   input  logic         dec_range,
   input  logic         range_trial,
   input  logic         comp,
   output logic [W-1:0] dac_code,
   output logic [W-1:0] data,
   output logic         oor,
   output logic         last_bit
);
   localparam int BW = $clog2(W);
   localparam logic [W-1:0] MSB_CODE = {1'b1, {(W-1){1'b0}}};

   generate
      if (W < 2) begin : g_bad_w
         $error("sarseq_sar: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  code;
   logic [BW-1:0] bidx;

   assign last_bit = (bidx == '0);
   assign data     = code;
   assign dac_code = range_trial ? {W{1'b1}} : code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         bidx <= '0;
         oor  <= 1'b0;
      end else if (load) begin
         code <= MSB_CODE;
         bidx <= BW'(W - 1);
         oor  <= 1'b0;
      end else if (dec_data) begin
         code[bidx] <= comp;
         if (bidx != '0) begin
            code[bidx - BW'(1)] <= 1'b1;
            bidx                <= bidx - BW'(1);
         end
      end else if (dec_range) begin
         oor <= comp;
      end
   end

   // R4: a data decision settles one bit and raises at most the next one
   a_r4_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
      dec_data |=> ($countones(code ^ $past(code)) <= 2));
endmodule

// File: rtl/sarseq_core.sv
module sarseq_core #(
   parameter int DATA_W  = 12,
   parameter int DIV     = 4,
   parameter bit SLIP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              comp_i,
   input  logic              bus_sel_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   output logic [DATA_W-1:0] dac_code_o,
   output logic [DATA_W:0]   word_o,
   output logic              word_wr_o
);
   import sarseq_pkg::*;

   localparam int WORD_W = DATA_W + 1;

   sar_phase_e        phase;
   logic              start_q, start_rise, accept;
   logic              bus_hold, at_end, decide_slot, stall, strobe;
   logic              dec_data, dec_range, xfer_done;
   logic              last_bit, oor;
   logic [DATA_W-1:0] data;

   assign start_rise  = start_i && !start_q;
   assign accept      = (phase == PH_IDLE) && start_rise;
   assign decide_slot = (phase == PH_DATA) || (phase == PH_RANGE);
   assign stall       = decide_slot && at_end && bus_hold;
   assign strobe      = decide_slot && at_end && !bus_hold;
   assign dec_data    = strobe && (phase == PH_DATA);
   assign dec_range   = strobe && (phase == PH_RANGE);
   assign xfer_done   = (phase == PH_XFER) && at_end;

   sarseq_busgate #(.SLIP_EN(SLIP_EN)) u_gate (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_hold(bus_hold));

   sarseq_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .run(phase != PH_IDLE), .stall(stall), .at_end(at_end));

   sarseq_sar #(.W(DATA_W)) u_sar (
      .clk(clk), .rst_n(rst_n), .load(accept), .dec_data(dec_data),
      .dec_range(dec_range), .range_trial(phase == PH_RANGE),
      .comp(comp_i), .dac_code(dac_code_o), .data(data),
      .oor(oor), .last_bit(last_bit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q   <= 1'b0;
         phase     <= PH_IDLE;
         word_o    <= '0;
         word_wr_o <= 1'b0;
      end else begin
         start_q   <= start_i;
         word_wr_o <= 1'b0;
         unique case (phase)
            PH_IDLE:  if (accept) phase <= PH_DATA;
            PH_DATA:  if (dec_data && last_bit) phase <= PH_RANGE;
            PH_RANGE: if (dec_range) phase <= PH_XFER;
            PH_XFER:  if (xfer_done) begin
                         phase     <= PH_IDLE;
                         word_o    <= WORD_W'({oor, data});
                         word_wr_o <= 1'b1;
                      end
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   // R6: the transfer strobe lasts one cycle
   a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      word_wr_o |=> !word_wr_o);
   // R7: a deferred decision leaves the trial code untouched
   a_r7_defer_holds_code: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> $stable(dac_code_o));
endmodule

// File: tb/sarseq_core_test.sv
module sarseq_core_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        comp_i;
   logic        bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [11:0] dac_code_o;
   logic [12:0] word_o;
   logic        word_wr_o;
   logic [12:0] ana = '0;
   int          total = 0, bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   // ideal comparator model
   assign comp_i = (ana >= {1'b0, dac_code_o});

   sarseq_core uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_i(comp_i),
      .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .dac_code_o(dac_code_o), .word_o(word_o), .word_wr_o(word_wr_o));

   typedef struct packed {
      logic [12:0] a;
      logic [7:0]  bus_at;
      logic [3:0]  bus_len;
      logic [1:0]  kind;   // 0 none, 1 read, 2 write, 3 read without select
      logic [12:0] exp_word;
      logic [7:0]  exp_lat;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{13'd0,     8'd0,  4'd0, 2'd0, 13'h0000, 8'd56},
      '{13'd4095,  8'd0,  4'd0, 2'd0, 13'h1FFF, 8'd56},
      '{13'd2048,  8'd0,  4'd0, 2'd0, 13'h0800, 8'd56},
      '{13'h0555,  8'd3,  4'd1, 2'd1, 13'h0555, 8'd57},
      '{13'h0AAA,  8'd3,  4'd3, 2'd2, 13'h0AAA, 8'd59},
      '{13'h0123,  8'd4,  4'd1, 2'd1, 13'h0123, 8'd56},
      '{13'h07FF,  8'd3,  4'd3, 2'd3, 13'h07FF, 8'd56},
      '{13'd5000,  8'd0,  4'd0, 2'd0, 13'h1FFF, 8'd56},
      '{13'd4094,  8'd0,  4'd0, 2'd0, 13'h0FFE, 8'd56},
      '{13'h00F0,  8'd51, 4'd1, 2'd2, 13'h00F0, 8'd57},
      '{13'h03C3,  8'd55, 4'd1, 2'd1, 13'h03C3, 8'd56}
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic bus_drive(input logic [1:0] kind, input bit on);
      bus_sel_n = !(on && kind != 2'd3);
      bus_rd_n  = !(on && (kind == 2'd1 || kind == 2'd3));
      bus_wr_n  = !(on && kind == 2'd2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired got=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int got_lat;
      logic [12:0] got_word;
      repeat (3) step();
      // R1: reset state
      chk("R1 dac after reset", dac_code_o, 0);
      chk("R1 word after reset", word_o, 0);
      chk("R1 strobe after reset", word_wr_o, 0);
      rst_n = 1'b1;
      repeat (2) step();

      // table-driven conversions
      for (int v = 0; v < NV; v++) begin
         ana = VECS[v].a;
         start_i = 1'b0;
         repeat (2) step();
         start_i = 1'b1;
         got_lat = 0;
         got_word = '0;
         for (int k = 1; k <= 64; k++) begin
            step();
            if (word_wr_o && got_lat == 0) begin
               got_lat = k;
               got_word = word_o;
            end else if (got_lat != 0 && k == got_lat + 1) begin
               chk("R6 strobe single cycle", word_wr_o, 0);
               chk("R6 word held", word_o, VECS[v].exp_word);
            end
            if (k == VECS[v].bus_at) bus_drive(VECS[v].kind, 1'b1);
            if (k == VECS[v].bus_at + VECS[v].bus_len) bus_drive(VECS[v].kind, 1'b0);
         end
         bus_drive(2'd0, 1'b0);
         chk("R4 R5 R6 result word", got_word, VECS[v].exp_word);
         chk("R3 R7 R8 R9 conversion length", got_lat, VECS[v].exp_lat);
      end

      // R2 R3 R4 R5: trial code sequence with input at zero
      ana = 13'd0;
      start_i = 1'b0;
      repeat (2) step();
      start_i = 1'b1;
      for (int k = 1; k <= 60; k++) begin
         step();
         if (k == 1)  chk("R2 MSB trial after start edge", dac_code_o, 12'h800);
         if (k == 3)  chk("R3 no decision before edge 4", dac_code_o, 12'h800);
         if (k == 4)  chk("R3 R4 first decision at edge 4", dac_code_o, 12'h400);
         if (k == 8)  chk("R3 second decision at edge 8", dac_code_o, 12'h200);
         if (k == 47) chk("R3 LSB trial pending", dac_code_o, 12'h001);
         if (k == 48) chk("R5 range trial code all ones", dac_code_o, 12'hFFF);
         if (k == 55) chk("R6 no strobe before edge 56", word_wr_o, 0);
         if (k == 56) chk("R6 strobe after edge 56", word_wr_o, 1);
      end

      // R10: restart pulse mid-conversion is ignored
      ana = 13'h0321;
      start_i = 1'b0;
      repeat (2) step();
      start_i = 1'b1;
      got_lat = 0;
      got_word = '0;
      for (int k = 1; k <= 130; k++) begin
         step();
         if (word_wr_o) begin
            if (got_lat == 0) begin
               got_lat = k;
               got_word = word_o;
            end else begin
               chk("R10 no second conversion", k, 0);
            end
         end
         if (k == 20) start_i = 1'b0;
         if (k == 22) start_i = 1'b1;
      end
      chk("R10 result with restart pulse", got_word, 13'h0321);
      chk("R10 length with restart pulse", got_lat, 56);
      chk("R10 trial code not restarted", dac_code_o, 12'h321);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule